// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block sits on the read path of a parallel NOR-style flash model. While an internal program or erase is running, it replaces array data on the data pins with a status byte, so the host can follow the operation by reading. The status byte carries six things: a data-polling bit, two toggle bits, a failure bit, an erase-window bit and a buffer-abort bit. The block also drives an active-low ready/busy pin. The controller that sequences the operation is stubbed as plain inputs: start, kind, target address and byte, done, limit-exceeded, reset command, suspend level, window level and abort level.

The bits react to reads. A read access ends when chip-enable or output-enable goes high while both were low. That edge advances the toggle bits. The values returned also depend on whether the read address falls inside the sector being erased, and on whether the erase is suspended.

The controller is a five-state machine:
- IDLE: no operation.
- PROG: program running.
- ERASE: chip or sector erase running.
- SUSP: sector erase suspended.
- FAIL: pulse-count limit exceeded.

Its transitions are:
- START: IDLE to PROG, or IDLE to ERASE.
- DONE: PROG to IDLE, or ERASE to IDLE.
- OVERRUN: PROG to FAIL, or ERASE to FAIL.
- SUSPEND: ERASE to SUSP, sector erase only.
- RESUME: SUSP to ERASE.
- CLEAR: FAIL to IDLE.

Top module: `flash_status_gen`

## Requirements
- R1: After reset the block is in IDLE, `rb_n` is 1 and `dq` equals `array_q`. Both toggle bits start at 0.
- R2: The status word is driven in PROG, ERASE and FAIL at any address. In SUSP it is driven only for addresses inside the target sector. In every other case `dq` equals `array_q`. The sector is the top `SEC_W` address bits.
- R3: `op_kind` encodes 0 as program, 1 as chip erase and 2 as sector erase. In PROG, bit 7 of the status is the inverse of bit 7 of the captured `op_byte`. After DONE, reads return array data.
- R4: In ERASE, bit 7 reads 0 for a chip erase at any address. For a sector erase it reads 0 inside the target sector and 1 outside it. In SUSP, bit 7 reads 1.
- R5: Status bit 6 inverts at the end of every read access in PROG, ERASE and FAIL. It is otherwise unchanged.
- R6: In SUSP, bit 6 holds steady while bit 2 inverts at the end of each read inside the target sector. Reads outside the sector return array data. In ERASE, bit 2 inverts at the end of every read. After RESUME, both bits toggle again.
- R7: OVERRUN (`limit_hit`) in PROG or ERASE moves the block to FAIL. FAIL persists until `reset_cmd`, ignoring `op_done`. In FAIL, bit 5 is 1, bit 7 is 0 and bit 6 keeps toggling.
- R8: Status bit 3 is the inverse of `erase_win_open` in ERASE and SUSP, and 0 in other states.
- R9: Status bit 1 follows `wbuf_abort` whenever the status word is driven.
- R10: In the status word, bits 4, 0 and all bits above 7 are 0.
- R11: `rb_n` is 0 in PROG, ERASE and FAIL, and 1 in IDLE and SUSP.
- R12: A read access is counted only when chip-enable and output-enable were both low. Output-enable pulses while chip-enable is high advance no toggle bit.
- R13: `op_start` is ignored outside IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_start | input | 1 | Operation start pulse |
| op_kind | input | 2 | 0 program, 1 chip erase, 2 sector erase |
| op_addr | input | ADDR_W | Target address (its top bits give the sector) |
| op_byte | input | 8 | Byte being programmed |
| op_done | input | 1 | Operation completed pulse |
| limit_hit | input | 1 | Pulse-count limit exceeded pulse |
| reset_cmd | input | 1 | Reset command pulse that clears a failure |
| erase_suspend | input | 1 | Erase-suspend level |
| erase_win_open | input | 1 | Multi-sector acceptance window open |
| wbuf_abort | input | 1 | Buffered write aborted |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Read address |
| array_q | input | DATA_W | Array read data |
| dq | output | DATA_W | Data pins |
| rb_n | output | 1 | Ready (1) / busy (0) |

## Verification
The assertions check several properties on every cycle:
- FAIL stays put until a reset command arrives.
- Bit 6 never moves in SUSP.
- The toggle registers move only when told to.
- `rb_n` rises only after a done, a reset command or a suspend.
- The reserved and upper bits of the status word stay 0.
- Idle reads pass array data through.

Only the bench scenarios can show the remaining behaviour. This covers the read-counted toggle sequences and the address dependence of bit 7 inside and outside the erased sector. It also covers the split between bit 2 and bit 6 in suspend and resume, and that output-enable pulses without chip-enable are not counted.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
    typedef enum logic [1:0] {
        K_PROG   = 2'd0,
        K_CHIP   = 2'd1,
        K_SECTOR = 2'd2,
        K_NONE   = 2'd3
    } op_kind_e;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PROG  = 3'd1,
        S_ERASE = 3'd2,
        S_SUSP  = 3'd3,
        S_FAIL  = 3'd4
    } fsg_state_e;
endpackage

// File: rtl/fsg_read_watch.sv
module fsg_read_watch (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    output logic read_end
);
    logic active, active_q;

    assign active = ~ce_n & ~oe_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) active_q <= 1'b0;
        else        active_q <= active;
    end

    // R12: only a completed access with both strobes low counts
    assign read_end = active_q & ~active;
endmodule

// File: rtl/fsg_toggle.sv
module fsg_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    output logic q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= 1'b0;
        else if (adv) q <= ~q;
    end

    assert_toggle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(q));
endmodule

// File: rtl/fsg_ctrl.sv
module fsg_ctrl
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEC_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_byte,
    input  logic              op_done,
    input  logic              limit_hit,
    input  logic              reset_cmd,
    input  logic              erase_suspend,
    output fsg_state_e        state,
    output logic              is_sector,
    output logic [SEC_W-1:0]  tsec,
    output logic              pbit7,
    output logic              rb_n
);
    fsg_state_e nxt;
    op_kind_e   kind;

    assign kind = op_kind_e'(op_kind);

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (op_start) begin
                    if (kind == K_PROG) nxt = S_PROG;
                    else if (kind == K_CHIP || kind == K_SECTOR) nxt = S_ERASE;
                end
            end
            S_PROG: begin
                if (limit_hit)    nxt = S_FAIL;
                else if (op_done) nxt = S_IDLE;
            end
            S_ERASE: begin
                if (limit_hit)                        nxt = S_FAIL;
                else if (op_done)                     nxt = S_IDLE;
                else if (erase_suspend && is_sector)  nxt = S_SUSP;
            end
            S_SUSP: if (!erase_suspend) nxt = S_ERASE;
            S_FAIL: if (reset_cmd)      nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            is_sector <= 1'b0;
            tsec      <= '0;
            pbit7     <= 1'b0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && op_start) begin
                is_sector <= (kind == K_SECTOR);
                tsec      <= op_addr[ADDR_W-1 -: SEC_W];
                pbit7     <= op_byte[7];
            end
        end
    end

    always_comb begin
        unique case (state)
            S_PROG, S_ERASE, S_FAIL: rb_n = 1'b0;
            default:                 rb_n = 1'b1;
        endcase
    end

    assert_fail_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_FAIL && !reset_cmd) |=> state == S_FAIL);
    assert_ready_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rb_n) |-> ($past(op_done) || $past(reset_cmd) || $past(erase_suspend)));
    assert_start_ignored_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PROG && !limit_hit && !op_done) |=> state == S_PROG);
endmodule

// File: rtl/fsg_status_mux.sv
module fsg_status_mux
    import fsg_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  fsg_state_e        state,
    input  logic              is_sector,
    input  logic              in_sec,
    input  logic              pbit7,
    input  logic              t6,
    input  logic              t2,
    input  logic              erase_win_open,
    input  logic              wbuf_abort,
    input  logic [DATA_W-1:0] array_q,
    output logic              show,
    output logic [DATA_W-1:0] dq
);
    logic [7:0] stat;

    always_comb begin
        stat = 8'h00;
        show = 1'b1;
        unique case (state)
            S_IDLE: show = 1'b0;
            S_PROG: stat[7] = ~pbit7;
            S_ERASE: begin
                stat[7] = is_sector & ~in_sec;
                stat[3] = ~erase_win_open;
            end
            S_SUSP: begin
                show    = in_sec;
                stat[7] = 1'b1;
                stat[3] = ~erase_win_open;
            end
            S_FAIL: stat[5] = 1'b1;
            default: show = 1'b0;
        endcase
        stat[6] = t6;
        stat[2] = t2;
        stat[1] = wbuf_abort;
    end

    always_comb begin
        dq = '0;
        if (show) dq[7:0] = stat;
        else      dq = array_q;
    end
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import fsg_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int SEC_W  = 2,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_start,
    input  logic [1:0]        op_kind,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_byte,
    input  logic              op_done,
    input  logic              limit_hit,
    input  logic              reset_cmd,
    input  logic              erase_suspend,
    input  logic              erase_win_open,
    input  logic              wbuf_abort,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] array_q,
    output logic [DATA_W-1:0] dq,
    output logic              rb_n
);
    fsg_state_e       state;
    logic             is_sector, pbit7, read_end, in_sec, show;
    logic             t6, t2, adv6, adv2;
    logic [SEC_W-1:0] tsec;

    fsg_ctrl #(.ADDR_W(ADDR_W), .SEC_W(SEC_W)) u_ctrl (
        .clk, .rst_n, .op_start, .op_kind, .op_addr, .op_byte, .op_done,
        .limit_hit, .reset_cmd, .erase_suspend,
        .state, .is_sector, .tsec, .pbit7, .rb_n
    );

    fsg_read_watch u_watch (.clk, .rst_n, .ce_n, .oe_n, .read_end);

    assign in_sec = (addr[ADDR_W-1 -: SEC_W] == tsec);
    assign adv6   = read_end & (state == S_PROG || state == S_ERASE || state == S_FAIL);
    assign adv2   = read_end & (state == S_ERASE || (state == S_SUSP && in_sec));

    fsg_toggle u_t6 (.clk, .rst_n, .adv(adv6), .q(t6));
    fsg_toggle u_t2 (.clk, .rst_n, .adv(adv2), .q(t2));

    fsg_status_mux #(.DATA_W(DATA_W)) u_mux (
        .state, .is_sector, .in_sec, .pbit7, .t6, .t2,
        .erase_win_open, .wbuf_abort, .array_q, .show, .dq
    );

    assert_susp_b6_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_SUSP) |=> $stable(t6));
    assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        show |-> (dq[4] == 1'b0 && dq[0] == 1'b0 && (dq >> 8) == '0));
    assert_idle_array_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> dq == array_q);
endmodule

// File: tb/flash_status_gen_tb.sv
module flash_status_gen_tb;
    localparam int ADDR_W = 8;
    localparam int SEC_W  = 2;
    localparam int DATA_W = 16;
    localparam logic [15:0] ARR = 16'h5A3C;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic op_start = 0, op_done = 0, limit_hit = 0, reset_cmd = 0;
    logic erase_suspend = 0, erase_win_open = 0, wbuf_abort = 0;
    logic ce_n = 1, oe_n = 1;
    logic [1:0] op_kind = 0;
    logic [7:0] op_addr = 0, op_byte = 0, addr = 0;
    logic [15:0] array_q = ARR;
    logic [15:0] dq;
    logic rb_n;

    always #5 clk = ~clk;

    flash_status_gen #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .DATA_W(DATA_W)) u_dut (
        .clk, .rst_n, .op_start, .op_kind, .op_addr, .op_byte, .op_done,
        .limit_hit, .reset_cmd, .erase_suspend, .erase_win_open, .wbuf_abort,
        .ce_n, .oe_n, .addr, .array_q, .dq, .rb_n
    );

    typedef struct { logic [15:0] edq; logic erb; string tag; } item_t;
    item_t sb[$];
    event  smp;
    int    n_chk = 0, n_bad = 0;
    bit    finished = 0;

    // Bench model: 0 idle, 1 program, 2 erase, 3 suspend, 4 fail
    int   m_mode = 0;
    logic m_b7 = 0, m_sector = 0, t6 = 0, t2 = 0;
    logic [1:0] m_sec = 0;

    function automatic logic [15:0] model(input logic [7:0] a);
        logic ins;
        logic [7:0] s;
        ins = (a[7:6] == m_sec);
        if (m_mode == 0 || (m_mode == 3 && !ins)) return ARR;
        s = 8'h00;
        case (m_mode)
            1: s[7] = ~m_b7;
            2: s[7] = m_sector & ~ins;
            3: s[7] = 1'b1;
            default: s[7] = 1'b0;
        endcase
        s[6] = t6;
        s[5] = (m_mode == 4);
        s[3] = (m_mode == 2 || m_mode == 3) & ~erase_win_open;
        s[2] = t2;
        s[1] = wbuf_abort;
        return {8'h00, s};
    endfunction

    task automatic rd(input logic [7:0] a, input string tag);
        item_t it;
        logic ins;
        @(negedge clk);
        addr = a; ce_n = 0; oe_n = 0;
        @(negedge clk);
        it.edq = model(a);
        it.erb = !(m_mode == 1 || m_mode == 2 || m_mode == 4);
        it.tag = tag;
        sb.push_back(it);
        ->smp;
        ins = (a[7:6] == m_sec);
        if (m_mode == 1 || m_mode == 2 || m_mode == 4) t6 = ~t6;
        if (m_mode == 2 || (m_mode == 3 && ins)) t2 = ~t2;
        ce_n = 1; oe_n = 1;
    endtask

    task automatic start(input logic [1:0] k, input logic [7:0] a, input logic [7:0] b);
        @(negedge clk);
        op_kind = k; op_addr = a; op_byte = b; op_start = 1;
        @(negedge clk);
        op_start = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); op_done = 1; @(negedge clk); op_done = 0;
    endtask

    initial begin
        forever begin
            @(smp);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                n_chk++;
                if (dq !== it.edq || rb_n !== it.erb) begin
                    n_bad++;
                    $display("FAIL %s: dq=%h rb_n=%b expected dq=%h rb_n=%b",
                             it.tag, dq, rb_n, it.edq, it.erb);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(8'h10, "R1 reset idle");

        // program with bit 7 = 0, start attempt ignored, abort bit, strobe rule
        start(2'd0, 8'h23, 8'h00); m_mode = 1; m_b7 = 0; m_sec = 2'd0;
        rd(8'h23, "R3 R11 program b7 inverse");
        rd(8'h23, "R5 program toggle");
        start(2'd1, 8'h00, 8'hFF);
        rd(8'h23, "R13 start ignored");
        @(negedge clk); wbuf_abort = 1;
        rd(8'hC3, "R9 abort bit R2 any addr");
        @(negedge clk); wbuf_abort = 0;
        @(negedge clk); oe_n = 0; @(negedge clk); oe_n = 1; @(negedge clk);
        rd(8'h23, "R12 oe pulse without ce");
        pulse_done(); m_mode = 0;
        rd(8'h23, "R3 array after done");

        // program with bit 7 = 1
        start(2'd0, 8'h40, 8'h80); m_mode = 1; m_b7 = 1; m_sec = 2'd1;
        rd(8'h40, "R3 program b7 set");
        pulse_done(); m_mode = 0;

        // chip erase
        start(2'd1, 8'h00, 8'h00); m_mode = 2; m_sector = 0; m_sec = 2'd0;
        rd(8'hF0, "R4 R8 chip erase window closed");
        @(negedge clk); erase_win_open = 1;
        rd(8'h70, "R8 R6 window open b2 toggles");
        @(negedge clk); erase_suspend = 1; @(negedge clk);
        rd(8'h70, "R6 suspend ignored for chip erase");
        @(negedge clk); erase_suspend = 0; erase_win_open = 0;
        pulse_done(); m_mode = 0;

        // sector erase, suspend, resume
        start(2'd2, 8'h45, 8'h00); m_mode = 2; m_sector = 1; m_sec = 2'd1;
        rd(8'h50, "R4 sector inside");
        rd(8'hC0, "R4 sector outside");
        @(negedge clk); erase_suspend = 1; @(negedge clk); m_mode = 3;
        rd(8'h50, "R6 R11 suspend inside");
        rd(8'h55, "R6 suspend b2 again");
        rd(8'h00, "R6 R2 suspend outside array");
        @(negedge clk); erase_suspend = 0; @(negedge clk); m_mode = 2;
        rd(8'h50, "R6 resume");
        rd(8'h50, "R6 resume toggles");
        pulse_done(); m_mode = 0;
        rd(8'h50, "R11 idle after erase");

        // failure
        start(2'd0, 8'h10, 8'hFF); m_mode = 1; m_b7 = 1; m_sec = 2'd0;
        @(negedge clk); limit_hit = 1; @(negedge clk); limit_hit = 0; m_mode = 4;
        rd(8'h10, "R7 fail");
        pulse_done();
        rd(8'h10, "R7 fail sticky toggle R10");
        @(negedge clk); reset_cmd = 1; @(negedge clk); reset_cmd = 0; m_mode = 0;
        rd(8'h10, "R7 cleared");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run hung, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule